// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block sits between an external memory interface engine and the pad drivers of a shared external bus. An outside master asks for the bus by pulling an active-low hold request. The block lets any access the engine has in flight finish. It then turns off the output enables for the address, data and control groups. Only after that does it pull an active-low acknowledge. When the request is withdrawn, the steps run in reverse: the acknowledge goes high first, and the bus is driven again on the following cycle.

The request is asynchronous to the block clock. It passes through a two-stage synchronizer before the state machine sees it. While the synchronizer is still filling after reset, the block treats the request as inactive. The state machine has five states:

- IDLE: the bus is owned and driven.
- DRAIN: the engine is stalled and its pending access completes.
- FLOAT: every output enable is off and the acknowledge is still high.
- GRANTED: the acknowledge is low.
- RELEASE: the acknowledge is high again but the bus still floats.

The transitions are:

- IDLE to DRAIN on a synchronized request.
- DRAIN to FLOAT once busy is low.
- DRAIN to IDLE on an abort.
- FLOAT to GRANTED while the request holds.
- FLOAT to IDLE on an abort.
- GRANTED to RELEASE when the request goes high.
- RELEASE to IDLE unconditionally.

A stall output holds the engine off in every state except IDLE. The bus values themselves pass straight through to the pads.

Top module: `bus_hold_ctrl`

## Requirements
- R1: During and right after reset, the acknowledge is high, the address and control enables are high, and the stall is low. An asynchronous reset in any state returns these outputs at once.
- R2: Edges are numbered from the first rising edge that samples the request low, counted as edge 0. With busy low, the stall rises after edge 2, all enables fall after edge 3, and the acknowledge falls after edge 4. A request that is already low when reset is released is not acted on before edge 2.
- R3: While the block is draining and busy is high, the bus stays driven and the acknowledge stays high. The bus floats one cycle after busy is sampled low.
- R4: The bus floats no later than 4 request-low edges after the request falls, and the acknowledge falls no later than 5. Each edge with busy high adds one edge to both bounds.
- R5: The acknowledge is never low while any output enable is high. It falls only after the bus has floated for at least one cycle.
- R6: Edges are numbered from the first rising edge that samples the request high, counted as edge 0. After the request goes high in GRANTED, the acknowledge rises after edge 2 (within 3 edges) and the enables return after edge 3 (within 4 edges). The enables never return in the same cycle that the acknowledge rises.
- R7: The stall is high in DRAIN, FLOAT, GRANTED and RELEASE, and low in IDLE.
- R8: If the synchronized request goes high in DRAIN or FLOAT, the block returns to IDLE and drives the bus. The acknowledge is never pulled low in that case.
- R9: The data enable is high only when the block owns the bus and the engine's direction input is 1 (1 = write). The address and control enables do not depend on direction.
- R10: The address, write data, read/write and chip-select values reach the pads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Active-low bus hold request from the outside master (asynchronous) |
| eng_busy | input | 1 | Engine has an access in progress |
| eng_data_dir | input | 1 | 1 = engine is writing and wants the data lines driven |
| eng_addr | input | ADDR_W | Address from the engine |
| eng_wdata | input | DATA_W | Write data from the engine |
| eng_rnw | input | 1 | Read/write strobe from the engine |
| eng_cs_n | input | CS_W | Chip selects from the engine |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| eng_stall | output | 1 | Holds off new engine accesses |
| pad_addr | output | ADDR_W | Address to the pads |
| pad_addr_oe | output | 1 | Address output enable |
| pad_wdata | output | DATA_W | Data to the pads |
| pad_data_oe | output | 1 | Data output enable |
| pad_rnw | output | 1 | Read/write strobe to the pads |
| pad_cs_n | output | CS_W | Chip selects to the pads |
| pad_ctrl_oe | output | 1 | Control output enable |

## Verification
The bound checker watches several rules on every cycle:

- the ordering rules, where the acknowledge never overlaps a driven bus, falls only after a floated cycle, and the bus returns only after the acknowledge is high;
- the coverage of the stall;
- the gating of the data enable;
- the worst-case latency bounds, counted from the raw request and stretched by busy cycles.

Only the bench scenarios show the following:

- the exact edge on which each output changes;
- that the abort paths never grant;
- that a request held low across reset waits for the synchronizer;
- that an asynchronous reset in GRANTED frees the bus.

// File: rtl/hbh_pkg.sv
package hbh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_FLOAT   = 3'd2,
        ST_GRANTED = 3'd3,
        ST_RELEASE = 3'd4
    } hbh_state_e;

    localparam int OE_GROUPS = 3;
    localparam int OE_ADDR   = 0;
    localparam int OE_DATA   = 1;
    localparam int OE_CTRL   = 2;

    // States in which the block has given up the pads.
    function automatic logic bus_released(hbh_state_e st);
        return (st == ST_FLOAT) || (st == ST_GRANTED) || (st == ST_RELEASE);
    endfunction

endpackage

// File: rtl/hbh_req_sync.sv
module hbh_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] fill;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("hbh_req_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            fill  <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], async_n};
            fill  <= {fill[STAGES-2:0], 1'b1};
        end
    end

    // Report the request as inactive until every stage has been loaded.
    assign sync_n = fill[LAST] ? chain[LAST] : 1'b1;

endmodule

// File: rtl/hbh_fsm.sv
module hbh_fsm
    import hbh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s_n,
    input  logic busy,
    output logic float_bus,
    output logic ack_n,
    output logic stall
);
    hbh_state_e state_q;
    hbh_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!req_s_n) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (req_s_n)    state_d = ST_IDLE;
                else if (!busy) state_d = ST_FLOAT;
            end
            ST_FLOAT:   state_d = req_s_n ? ST_IDLE : ST_GRANTED;
            ST_GRANTED: if (req_s_n) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        float_bus = bus_released(state_q);
        ack_n     = 1'b1;
        stall     = 1'b1;
        unique case (state_q)
            ST_IDLE:    stall = 1'b0;
            ST_DRAIN:   ;
            ST_FLOAT:   ;
            ST_GRANTED: ack_n = 1'b0;
            ST_RELEASE: ;
            default: begin
                stall     = 1'b0;
                float_bus = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hbh_oe_gate.sv
module hbh_oe_gate #(
    parameter int GROUPS = 3
) (
    input  logic              float_bus,
    input  logic [GROUPS-1:0] want,
    output logic [GROUPS-1:0] oe
);
    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            assign oe[g] = want[g] & ~float_bus;
        end
    endgenerate

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import hbh_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 16,
    parameter int CS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req_n,
    input  logic              eng_busy,
    input  logic              eng_data_dir,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_rnw,
    input  logic [CS_W-1:0]   eng_cs_n,
    output logic              hold_ack_n,
    output logic              eng_stall,
    output logic [ADDR_W-1:0] pad_addr,
    output logic              pad_addr_oe,
    output logic [DATA_W-1:0] pad_wdata,
    output logic              pad_data_oe,
    output logic              pad_rnw,
    output logic [CS_W-1:0]   pad_cs_n,
    output logic              pad_ctrl_oe
);
    logic                 req_s_n;
    logic                 float_bus;
    logic [OE_GROUPS-1:0] oe_want;
    logic [OE_GROUPS-1:0] oe_out;

    hbh_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (hold_req_n),
        .sync_n  (req_s_n)
    );

    hbh_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s_n   (req_s_n),
        .busy      (eng_busy),
        .float_bus (float_bus),
        .ack_n     (hold_ack_n),
        .stall     (eng_stall)
    );

    always_comb begin
        oe_want           = '0;
        oe_want[OE_ADDR]  = 1'b1;
        oe_want[OE_DATA]  = eng_data_dir;
        oe_want[OE_CTRL]  = 1'b1;
    end

    hbh_oe_gate #(.GROUPS(OE_GROUPS)) u_gate (
        .float_bus (float_bus),
        .want      (oe_want),
        .oe        (oe_out)
    );

    assign pad_addr_oe = oe_out[OE_ADDR];
    assign pad_data_oe = oe_out[OE_DATA];
    assign pad_ctrl_oe = oe_out[OE_CTRL];
    assign pad_addr    = eng_addr;
    assign pad_wdata   = eng_wdata;
    assign pad_rnw     = eng_rnw;
    assign pad_cs_n    = eng_cs_n;

endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk #(
    parameter int CNT_W      = 8,
    parameter int FLOAT_LIM  = 4,
    parameter int ACK_LIM    = 5,
    parameter int ACKREL_LIM = 3,
    parameter int DRIVE_LIM  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic hold_req_n,
    input logic eng_busy,
    input logic eng_data_dir,
    input logic hold_ack_n,
    input logic eng_stall,
    input logic pad_addr_oe,
    input logic pad_data_oe,
    input logic pad_ctrl_oe
);
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] busy_cnt;
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W:0]   float_allow;
    logic [CNT_W:0]   ack_allow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt   <= '0;
            busy_cnt <= '0;
            hi_cnt   <= '0;
        end else if (!hold_req_n) begin
            hi_cnt <= '0;
            if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
            if (eng_busy && busy_cnt != SAT) busy_cnt <= busy_cnt + 1'b1;
        end else begin
            lo_cnt   <= '0;
            busy_cnt <= '0;
            if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign float_allow = (CNT_W+1)'(FLOAT_LIM) + {1'b0, busy_cnt};
    assign ack_allow   = (CNT_W+1)'(ACK_LIM)   + {1'b0, busy_cnt};

    AST_BUSY_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_stall && pad_addr_oe && eng_busy) |=> (pad_addr_oe && hold_ack_n)); // R3
    AST_FLOAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, lo_cnt} >= float_allow) |-> (!pad_addr_oe && !pad_ctrl_oe)); // R4
    AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, lo_cnt} >= ack_allow) |-> !hold_ack_n); // R4
    AST_NO_ACK_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> (!pad_addr_oe && !pad_ctrl_oe && !pad_data_oe)); // R5
    AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> $past(!pad_addr_oe && !pad_ctrl_oe)); // R5
    AST_ACK_RELEASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= CNT_W'(ACKREL_LIM)) |-> hold_ack_n); // R6
    AST_BUS_RETURN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= CNT_W'(DRIVE_LIM)) |-> (pad_addr_oe && pad_ctrl_oe)); // R6
    AST_DRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_addr_oe) |-> (hold_ack_n && $past(hold_ack_n))); // R6
    AST_STALL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_addr_oe || !hold_ack_n) |-> eng_stall); // R7
    AST_DATA_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pad_data_oe |-> (eng_data_dir && pad_addr_oe)); // R9

endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_req_n   (hold_req_n),
    .eng_busy     (eng_busy),
    .eng_data_dir (eng_data_dir),
    .hold_ack_n   (hold_ack_n),
    .eng_stall    (eng_stall),
    .pad_addr_oe  (pad_addr_oe),
    .pad_data_oe  (pad_data_oe),
    .pad_ctrl_oe  (pad_ctrl_oe)
);

// File: tb/bus_hold_ctrl_tb_top.sv
module bus_hold_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 19;
    localparam int DW = 16;
    localparam int CW = 3;
    localparam int NVEC = 32;

    // {req_n, busy, exp_ack_n, exp_addr_oe, exp_data_oe, exp_stall}
    localparam logic [5:0] VEC [0:NVEC-1] = '{
        6'b001110, 6'b001110, 6'b001111, 6'b001001,
        6'b000001, 6'b000001, 6'b100001, 6'b100001,
        6'b101001, 6'b101110, 6'b101110, 6'b011110,
        6'b011110, 6'b011111, 6'b011111, 6'b001001,
        6'b000001, 6'b100001, 6'b100001, 6'b101001,
        6'b101110, 6'b001110, 6'b001110, 6'b101111,
        6'b101001, 6'b101110, 6'b011110, 6'b011110,
        6'b111111, 6'b111111, 6'b111110, 6'b101110
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold_req_n = 1'b1;
    logic          eng_busy = 1'b0;
    logic          eng_data_dir = 1'b1;
    logic [AW-1:0] eng_addr = '0;
    logic [DW-1:0] eng_wdata = '0;
    logic          eng_rnw = 1'b1;
    logic [CW-1:0] eng_cs_n = '1;
    logic          hold_ack_n;
    logic          eng_stall;
    logic [AW-1:0] pad_addr;
    logic          pad_addr_oe;
    logic [DW-1:0] pad_wdata;
    logic          pad_data_oe;
    logic          pad_rnw;
    logic [CW-1:0] pad_cs_n;
    logic          pad_ctrl_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_hold_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CS_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .eng_busy(eng_busy),
        .eng_data_dir(eng_data_dir), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_rnw(eng_rnw), .eng_cs_n(eng_cs_n), .hold_ack_n(hold_ack_n),
        .eng_stall(eng_stall), .pad_addr(pad_addr), .pad_addr_oe(pad_addr_oe),
        .pad_wdata(pad_wdata), .pad_data_oe(pad_data_oe), .pad_rnw(pad_rnw),
        .pad_cs_n(pad_cs_n), .pad_ctrl_oe(pad_ctrl_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: state held in reset
        #(CLK_PERIOD*2 + 1);
        chk("R1 ack in reset", hold_ack_n, 1'b1);
        chk("R1 addr oe in reset", pad_addr_oe, 1'b1);
        chk("R1 ctrl oe in reset", pad_ctrl_oe, 1'b1);
        chk("R1 stall in reset", eng_stall, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        repeat (4) step();
        chk("R1 ack after reset", hold_ack_n, 1'b1);

        // R9 and R10: direction gating and pass-through while owned
        @(negedge clk);
        eng_data_dir = 1'b0;
        eng_addr = 19'h5A3C1;
        eng_wdata = 16'hBEEF;
        eng_rnw = 1'b0;
        eng_cs_n = 3'b101;
        #1;
        chk("R9 data oe dir 0", pad_data_oe, 1'b0);
        chk("R9 addr oe dir 0", pad_addr_oe, 1'b1);
        chk("R10 addr", pad_addr, 32'h5A3C1);
        chk("R10 wdata", pad_wdata, 32'hBEEF);
        chk("R10 rnw", pad_rnw, 1'b0);
        chk("R10 cs", pad_cs_n, 3'b101);
        @(negedge clk) eng_data_dir = 1'b1;
        #1;
        chk("R9 data oe dir 1", pad_data_oe, 1'b1);
        repeat (4) step();

        // Table walk: R2, R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            hold_req_n = VEC[i][5];
            eng_busy = VEC[i][4];
            step();
            chk($sformatf("R2 R5 R6 R8 ack v%0d", i), hold_ack_n, VEC[i][3]);
            chk($sformatf("R3 R4 R6 addr oe v%0d", i), pad_addr_oe, VEC[i][2]);
            chk($sformatf("R9 data oe v%0d", i), pad_data_oe, VEC[i][1]);
            chk($sformatf("R7 stall v%0d", i), eng_stall, VEC[i][0]);
        end
        repeat (4) step();

        // R2: request held low across reset waits for the synchronizer
        @(negedge clk);
        rst_n = 1'b0;
        hold_req_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R2 early edge0 stall", eng_stall, 1'b0);
        step();
        chk("R2 early edge1 stall", eng_stall, 1'b0);
        step();
        chk("R2 early edge2 stall", eng_stall, 1'b1);
        step();
        chk("R2 early edge3 addr oe", pad_addr_oe, 1'b0);
        step();
        chk("R2 early edge4 ack", hold_ack_n, 1'b0);

        // R1: asynchronous reset while granted
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R1 reset in grant ack", hold_ack_n, 1'b1);
        chk("R1 reset in grant addr oe", pad_addr_oe, 1'b1);
        chk("R1 reset in grant stall", eng_stall, 1'b0);
        @(negedge clk) hold_req_n = 1'b1;
        @(negedge clk) rst_n = 1'b1;
        repeat (3) step();

        done = 1'b1;
        finish_run();
    end

endmodule